// File: doc/BRIEF.md
# Beacon Preamble Search and Alignment Engine

This block performs coarse acquisition for an impulse-radio receiver that listens for beacons. A correlator upstream despreads each received pulse against the candidate code the block currently selects. It then delivers one signed correlation value per pulse. The block tries the candidate codes one after another. For each candidate it sums the correlation over a fixed dwell of several code repetitions and compares the total with a programmable threshold. When a dwell ends at or above the threshold, the candidate is declared found.

Once a candidate is found, the block switches to alignment. It keeps summing the correlation one code repetition at a time and records the sign of each repetition's sum in a short history. The preamble ends with a fixed polarity signature on its last five repetitions. When the history matches that signature, the block emits a one-cycle end-of-preamble strobe and returns to idle. The index of the candidate that was found stays on the index output.

Top module: `beacon_acq`

## Requirements
- R1: After reset the candidate index is 1 and both `detected` and `eop_strobe` are low.
- R2: A `start` pulse while idle begins a search at candidate 1. `start` has no effect while a search or an alignment is under way.
- R3: A dwell is `INT_REPS*SEQ_LEN` valid pulses (default 3*79 = 237). If the signed sum over the dwell is greater than or equal to `thresh`, `detected` rises on the clock edge that takes the last pulse of the dwell, and the index keeps the found candidate.
- R4: If a dwell ends below `thresh`, the index moves to the next candidate on that edge. It wraps from `NUM_SEQ` (default 20) back to 1, and a new dwell starts.
- R5: Cycles with `corr_valid` low change no sum, counter or index.
- R6: During alignment, each repetition of `SEQ_LEN` valid pulses yields one sign bit: 1 when its sum is zero or positive, 0 when negative. The sign history starts empty (all 0) at detection.
- R7: `eop_strobe` is high for exactly one cycle, on the edge that takes the last pulse of a repetition for which the five most recent signs, oldest first, are +,+,-,-,+. `detected` falls on that same edge and the block is idle again.
- R8: `detected` stays high from detection until that strobe and cannot fall otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search from idle |
| corr_valid | input | 1 | `corr` holds a new pulse result |
| corr | input | CORR_W (8) | Signed correlation of one pulse |
| thresh | input | ACC_W (17) | Signed detection threshold |
| seq_idx | output | IDX_W (5) | Current or found candidate, 1..NUM_SEQ |
| detected | output | 1 | Candidate found, alignment in progress |
| eop_strobe | output | 1 | One-cycle end-of-preamble marker |

## Verification
Threshold detection and the index wrap are both decided on the edge that closes a dwell. When that dwell belongs to the last candidate, a hit must hold the index at 20 and a miss must move it to 1. The bench provokes this directly. It first runs a full sweep whose per-dwell total sits one below the threshold, so every candidate misses and the index wraps. It then runs a dwell on candidate 20 whose total exactly equals the threshold. A cycle-accurate reference model in the bench judges the index and `detected` on every cycle, so a wrong choice between the two outcomes is caught on the edge where it happens.

// File: rtl/beacon_acq.sv
module beacon_acq #(
  parameter int SEQ_LEN  = 79,
  parameter int NUM_SEQ  = 20,
  parameter int INT_REPS = 3,
  parameter int CORR_W   = 8,
  parameter int SIG_LEN  = 5,
  parameter logic [SIG_LEN-1:0] SIG = 5'b11001,
  localparam int ACC_W = CORR_W + $clog2(SEQ_LEN*INT_REPS) + 1,
  localparam int IDX_W = $clog2(NUM_SEQ+1),
  localparam int PC_W  = $clog2(SEQ_LEN),
  localparam int RC_W  = (INT_REPS > 1) ? $clog2(INT_REPS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    corr_valid,
  input  logic signed [CORR_W-1:0] corr,
  input  logic signed [ACC_W-1:0]  thresh,
  output logic [IDX_W-1:0]        seq_idx,
  output logic                    detected,
  output logic                    eop_strobe
);
  typedef enum logic [1:0] {S_IDLE, S_SRCH, S_ALGN} st_t;

  st_t                     state;
  logic [PC_W-1:0]         pc;
  logic [RC_W-1:0]         rc;
  logic signed [ACC_W-1:0] acc;
  logic [SIG_LEN-1:0]      sgn;

  wire pc_last = (pc == PC_W'(SEQ_LEN-1));
  wire rc_last = (rc == RC_W'(INT_REPS-1));
  wire signed [ACC_W-1:0] sum_next = acc + {{(ACC_W-CORR_W){corr[CORR_W-1]}}, corr};
  wire hit = (sum_next >= thresh);
  wire [SIG_LEN-1:0] sgn_next = {sgn[SIG_LEN-2:0], ~sum_next[ACC_W-1]};

  assign detected = (state == S_ALGN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      seq_idx    <= IDX_W'(1);
      pc         <= '0;
      rc         <= '0;
      acc        <= '0;
      sgn        <= '0;
      eop_strobe <= 1'b0;
    end else begin
      eop_strobe <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_SRCH;
          seq_idx <= IDX_W'(1);
          pc      <= '0;
          rc      <= '0;
          acc     <= '0;
        end
        S_SRCH: if (corr_valid) begin
          pc <= pc_last ? '0 : pc + 1'b1;
          if (pc_last && rc_last) begin
            acc <= '0;
            rc  <= '0;
            if (hit) begin
              state <= S_ALGN;
              sgn   <= '0;
            end else begin
              seq_idx <= (seq_idx == IDX_W'(NUM_SEQ)) ? IDX_W'(1) : seq_idx + 1'b1;
            end
          end else begin
            acc <= sum_next;
            if (pc_last) rc <= rc + 1'b1;
          end
        end
        S_ALGN: if (corr_valid) begin
          pc <= pc_last ? '0 : pc + 1'b1;
          if (pc_last) begin
            acc <= '0;
            sgn <= sgn_next;
            if (sgn_next == SIG) begin
              eop_strobe <= 1'b1;
              state      <= S_IDLE;
            end
          end else begin
            acc <= sum_next;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module beacon_acq_chk #(
  parameter int NUM_SEQ = 20,
  parameter int IDX_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             corr_valid,
  input logic [IDX_W-1:0] seq_idx,
  input logic             detected,
  input logic             eop_strobe
);
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idx >= IDX_W'(1)) && (seq_idx <= IDX_W'(NUM_SEQ)));

  assert_eop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eop_strobe |=> !eop_strobe);

  assert_eop_leaves_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eop_strobe |-> (!detected && $past(detected)));

  assert_detect_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    detected |=> (detected || eop_strobe));

  assert_detect_on_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detected) |-> $past(corr_valid));

  assert_idx_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seq_idx) |-> ($past(corr_valid) || $past(start)));
endmodule

bind beacon_acq beacon_acq_chk #(.NUM_SEQ(NUM_SEQ), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_beacon_acq.sv
module test_beacon_acq;
  localparam int L = 79, N = 20, R = 3, CW = 8;
  localparam int AW = CW + $clog2(L*R) + 1;

  logic clk = 0, rst_n = 0, start = 0, corr_valid = 0;
  logic signed [CW-1:0] corr = '0;
  logic signed [AW-1:0] thresh = AW'(111);
  logic [4:0] seq_idx;
  logic detected, eop_strobe;

  always #5 clk = ~clk;

  beacon_acq i_beacon_acq (.clk, .rst_n, .start, .corr_valid, .corr, .thresh,
                           .seq_idx, .detected, .eop_strobe);

  int total = 0, bad = 0, eop_seen = 0;
  int m_st = 0, m_idx = 1, m_pc = 0, m_rc = 0, m_acc = 0, m_rep = 0, m_eop = 0;
  bit [4:0] m_sh = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model(input bit s, input bit v, input int c);
    int t;
    m_eop = 0;
    case (m_st)
      0: if (s) begin m_st = 1; m_idx = 1; m_pc = 0; m_rc = 0; m_acc = 0; end
      1: if (v) begin
        if (m_pc == L-1 && m_rc == R-1) begin
          t = m_acc + c; m_pc = 0; m_rc = 0; m_acc = 0;
          if (t >= int'(thresh)) begin m_st = 2; m_sh = 0; m_rep = 0; end
          else m_idx = (m_idx == N) ? 1 : m_idx + 1;
        end else begin
          m_acc += c;
          if (m_pc == L-1) begin m_pc = 0; m_rc++; end else m_pc++;
        end
      end
      2: if (v) begin
        if (m_pc == L-1) begin
          t = m_rep + c; m_pc = 0; m_rep = 0;
          m_sh = {m_sh[3:0], (t >= 0)};
          if (m_sh == 5'b11001) begin m_eop = 1; m_st = 0; end
        end else begin m_rep += c; m_pc++; end
      end
      default: ;
    endcase
  endtask

  task automatic step(input bit s, input bit v, input int c);
    @(negedge clk);
    chk(seq_idx == 5'(m_idx), "R4 index", seq_idx, m_idx);
    chk(detected == (m_st == 2), "R3 detected", detected, m_st == 2);
    chk(eop_strobe == m_eop[0], "R7 strobe", eop_strobe, m_eop);
    if (eop_strobe) eop_seen++;
    start = s; corr_valid = v; corr = CW'(c);
    model(s, v, c);
  endtask

  task automatic pulse(input int c, input bit gaps);
    if (gaps && ($urandom % 4 == 0)) step(0, 0, 100);
    step(0, 1, c);
  endtask

  task automatic window(input int c, input bit gaps);
    for (int i = 0; i < L*R; i++) pulse(c, gaps);
  endtask

  task automatic rep_sum(input int kind);
    for (int i = 0; i < L; i++) begin
      case (kind)
        0: pulse(2, 1);
        1: pulse(-2, 1);
        2: pulse((i == 0) ? 0 : ((i % 2) ? 1 : -1), 1);
        default: pulse((i == 0) ? -1 : ((i % 2) ? 1 : -1), 1);
      endcase
    end
  endtask

  initial begin
    int e0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(seq_idx == 1, "R1 idx", seq_idx, 1);
    chk(!detected, "R1 detected", detected, 0);
    chk(!eop_strobe, "R1 strobe", eop_strobe, 0);

    for (int i = 0; i < 20; i++) step(0, 1, 5);
    step(0, 0, 0);
    chk(!detected && seq_idx == 1, "R2 no start", detected, 0);

    thresh = AW'(L*R + 1);
    step(1, 0, 0);
    for (int k = 0; k < N; k++) window(1, 1);
    step(0, 0, 0);
    chk(seq_idx == 1, "R4 wrap", seq_idx, 1);
    chk(!detected, "R5 gaps ignored", detected, 0);

    thresh = AW'(L*R);
    for (int k = 0; k < N-1; k++) window(0, 1);
    window(1, 1);
    step(0, 0, 0);
    chk(detected && seq_idx == N, "R3 equal at last candidate", seq_idx, N);

    step(1, 0, 0);
    step(0, 0, 0);
    chk(detected && seq_idx == N, "R2 start in align", detected, 1);

    e0 = eop_seen;
    for (int k = 0; k < 6; k++) rep_sum(0);
    rep_sum(0); rep_sum(0); rep_sum(1); rep_sum(3); rep_sum(1);
    step(0, 0, 0);
    chk(eop_seen == e0 && detected, "R8 no early strobe", eop_seen - e0, 0);
    rep_sum(0); rep_sum(0); rep_sum(1); rep_sum(3); rep_sum(2);
    step(0, 0, 0);
    step(0, 0, 0);
    chk(eop_seen == e0 + 1, "R6 zero sum positive", eop_seen - e0, 1);
    chk(!detected && seq_idx == N, "R7 idle after strobe", detected, 0);

    thresh = AW'(111);
    for (int run = 0; run < 3; run++) begin
      step(1, 0, 0);
      while (m_st != 2) begin
        if (m_idx == 7 + run) pulse(int'($urandom % 3) - 1 + 1, 1);
        else pulse(int'($urandom % 5) - 2, 1);
      end
      for (int k = 0; k < 4 + run; k++) rep_sum(int'($urandom % 2));
      rep_sum(0); rep_sum(0); rep_sum(1); rep_sum(1); rep_sum(0);
      step(0, 0, 0);
      step(0, 0, 0);
      chk(m_st == 0 && seq_idx == 5'(7 + run), "R6 random run", seq_idx, 7 + run);
    end

    step(0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule